// File: doc/BRIEF.md
# Wake Event PME Output Controller

This block turns four wake sources into one power-management-event output pin. The sources are a wake-up frame received, a magic packet received, a link change from down to up, and signal energy detected. Each source arrives as a single-cycle pulse and sets its own sticky status bit. The host clears a status bit by writing 1 to it. Each source has its own enable bit. The pin becomes active when any enabled status bit is set.

The pin polarity is programmable. An optional hold-off keeps the pin inactive until the device clocks report that they are running and ready for host access. The hold-off applies only while auto wake-up is enabled. Event detection and the sequencing of clock or power domains are handled elsewhere.

Top module: `pme_wake_ctrl`

## Requirements
- R1: A 1 on a bit of `evt_i` at a clock edge sets the matching bit of `status_o` from the next cycle on. A set bit stays set until it is cleared.
- R2: At an edge where `clr_we_i` is 1, each `status_o` bit with a 1 in `clr_mask_i` is cleared. Bits with 0 in the mask keep their value. While `clr_we_i` is 0 the mask has no effect.
- R3: If a bit is cleared and receives an event at the same edge, the event wins and the bit stays set.
- R4: Bit positions are shared by `evt_i`, `status_o`, `en_i` and `clr_mask_i`: bit 3 is wake-up frame, bit 2 is magic packet, bit 1 is link down-to-up, and bit 0 is signal energy.
- R5: A status bit whose `en_i` bit is 0 never makes the pin active. With no enabled status bit set, `pme_o` is at its inactive level.
- R6: With `pol_hi_i` = 1 the active level of `pme_o` is 1. With `pol_hi_i` = 0 the active level is 0. The inactive level is the opposite. A change of `pol_hi_i` moves the pin in the same cycle, with no intermediate active pulse while nothing is pending.
- R7: While `rst` is high, and in the first cycle after it falls, `status_o` is 0 and `pme_o` sits at the inactive level for the current `pol_hi_i`.
- R8: When `auto_wake_i`, `dly_en_i` and not `clk_rdy_i` are all true at an edge, the pin is inactive in the following cycle. Once `clk_rdy_i` rises, the pin becomes active one cycle later if an enabled status bit is pending.
- R9: While `auto_wake_i` is 0, `dly_en_i` and `clk_rdy_i` have no effect on the pin.
- R10: The pin reflects the enabled status and the hold-off condition sampled at the previous clock edge: it lags `status_o` by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 4 | Wake event pulses (bit 3 frame, 2 magic, 1 link up, 0 energy) |
| en_i | input | 4 | Per-event pin enables, same bit order |
| pol_hi_i | input | 1 | 1: pin active high, 0: pin active low |
| dly_en_i | input | 1 | Hold off assertion until clocks are ready |
| auto_wake_i | input | 1 | Auto wake-up enable; qualifies `dly_en_i` |
| clk_rdy_i | input | 1 | All clocks running and ready for host access |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 4 | Write-1-to-clear mask for status bits |
| status_o | output | 4 | Sticky event status |
| pme_o | output | 1 | Power-management-event pin |

## Verification
Two things can happen in the same cycle: an event pulse can arrive on a bit that the host is clearing, and the polarity can flip while an enable changes. The bench provokes the first on purpose, with a clear and an event on the same bit at one edge. The bit must then read back as set. The bench also provokes the second at random, including cycles where clock-ready toggles while the hold-off is armed. Every cycle is compared against a behavioural model that applies the event-over-clear rule and the pin equation.

// File: rtl/pme_pkg.sv
package pme_pkg;
    localparam int unsigned NUM_SRC = 4;

    localparam int unsigned SRC_ENERGY = 0;
    localparam int unsigned SRC_LINKUP = 1;
    localparam int unsigned SRC_MAGIC  = 2;
    localparam int unsigned SRC_FRAME  = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic pol_hi;
        logic dly_en;
        logic auto_wake;
    } pin_cfg_t;

    // Hold-off only counts when auto wake-up qualifies it.
    function automatic logic holdoff(input pin_cfg_t cfg, input logic clk_rdy);
        return cfg.auto_wake & cfg.dly_en & ~clk_rdy;
    endfunction

    // Drive level for a given request state.
    function automatic logic pin_level(input logic active, input logic pol_hi);
        return ~(active ^ pol_hi);
    endfunction
endpackage

// File: rtl/pme_status_reg.sv
module pme_status_reg
    import pme_pkg::*;
#(
    parameter int unsigned WIDTH = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] clr_mask_i,
    output logic [WIDTH-1:0] sticky_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_i[g]) begin
                bit_q <= 1'b1;
            end else if (clr_we_i && clr_mask_i[g]) begin
                bit_q <= 1'b0;
            end
        end
        assign sticky_o[g] = bit_q;
    end
endmodule

// File: rtl/pme_req_gate.sv
module pme_req_gate
    import pme_pkg::*;
#(
    parameter int unsigned WIDTH = NUM_SRC
) (
    input  logic [WIDTH-1:0] sticky_i,
    input  logic [WIDTH-1:0] en_i,
    input  pin_cfg_t         cfg_i,
    input  logic             clk_rdy_i,
    output logic             req_o
);
    logic pending;

    always_comb begin
        pending = |(sticky_i & en_i);
        req_o   = pending & ~holdoff(cfg_i, clk_rdy_i);
    end
endmodule

// File: rtl/pme_pin_drv.sv
module pme_pin_drv
    import pme_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic pol_hi_i,
    output logic pin_o
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else begin
            active_q <= req_i;
        end
    end

    // Flop-held request combined with the polarity register: no pulse on a polarity write while idle.
    assign pin_o = pin_level(active_q, pol_hi_i);
endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
    import pme_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               pol_hi_i,
    input  logic               dly_en_i,
    input  logic               auto_wake_i,
    input  logic               clk_rdy_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic               pme_o
);
    pin_cfg_t cfg;
    logic     req;

    assign cfg = '{pol_hi: pol_hi_i, dly_en: dly_en_i, auto_wake: auto_wake_i};

    pme_status_reg #(.WIDTH(NUM_SRC)) u_status (
        .clk        (clk),
        .rst        (rst),
        .set_i      (evt_i),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .sticky_o   (status_o)
    );

    pme_req_gate #(.WIDTH(NUM_SRC)) u_gate (
        .sticky_i  (status_o),
        .en_i      (en_i),
        .cfg_i     (cfg),
        .clk_rdy_i (clk_rdy_i),
        .req_o     (req)
    );

    pme_pin_drv u_pin (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .pol_hi_i (cfg.pol_hi),
        .pin_o    (pme_o)
    );
endmodule

// File: rtl/pme_wake_ctrl_chk.sv
module pme_wake_ctrl_chk
    import pme_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic               pol_hi_i,
    input logic               dly_en_i,
    input logic               auto_wake_i,
    input logic               clk_rdy_i,
    input logic               clr_we_i,
    input logic [NUM_SRC-1:0] clr_mask_i,
    input logic [NUM_SRC-1:0] status_o,
    input logic               pme_o
);
    // R1
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R2
    clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && ((clr_mask_i & evt_i) == '0)) |=> ((status_o & $past(clr_mask_i)) == '0));

    // R5
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_o & en_i) == '0) |=> (pme_o == !pol_hi_i));

    // R8
    holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_wake_i && dly_en_i && !clk_rdy_i) |=> (pme_o == !pol_hi_i));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_o == '0));
endmodule

bind pme_wake_ctrl pme_wake_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .en_i        (en_i),
    .pol_hi_i    (pol_hi_i),
    .dly_en_i    (dly_en_i),
    .auto_wake_i (auto_wake_i),
    .clk_rdy_i   (clk_rdy_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .status_o    (status_o),
    .pme_o       (pme_o)
);

// File: tb/pme_wake_ctrl_tb_top.sv
module pme_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] evt, en, clr_mask;
    logic       pol_hi, dly_en, auto_wake, clk_rdy, clr_we;
    logic [3:0] status;
    logic       pme;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R7";

    // behavioural reference state
    int m_status = 0;
    int m_active = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pme_wake_ctrl dut_i (
        .clk(clk), .rst(rst), .evt_i(evt), .en_i(en), .pol_hi_i(pol_hi),
        .dly_en_i(dly_en), .auto_wake_i(auto_wake), .clk_rdy_i(clk_rdy),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .status_o(status), .pme_o(pme)
    );

    always @(posedge clk) begin
        int nxt;
        int pend;
        int hold;
        cycles = cycles + 1;
        if (rst) begin
            m_status = 0;
            m_active = 0;
        end else begin
            pend = ((m_status & int'(en)) != 0) ? 1 : 0;
            hold = (auto_wake && dly_en && !clk_rdy) ? 1 : 0;
            m_active = (pend == 1 && hold == 0) ? 1 : 0;
            nxt = m_status;
            if (clr_we) nxt = nxt & ~int'(clr_mask);
            nxt = (nxt | int'(evt)) & 15;
            m_status = nxt;
        end
    end

    task automatic compare();
        int exp_pin;
        exp_pin = (m_active == 1) ? int'(pol_hi) : int'(!pol_hi);
        checks++;
        if (int'(status) != m_status) begin
            failures++;
            $display("FAIL %s status actual=%0h expected=%0h", cur_req, status, m_status);
        end
        checks++;
        if (int'(pme) != exp_pin) begin
            failures++;
            $display("FAIL %s pin actual=%0b expected=%0d", cur_req, pme, exp_pin);
        end
    endtask

    // one cycle: check outputs, then apply the next stimulus, all at the falling edge
    task automatic step(input logic [3:0] e, input logic cw, input logic [3:0] cm);
        @(negedge clk);
        compare();
        evt = e; clr_we = cw; clr_mask = cm;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(4'h0, 1'b0, 4'h0);
    endtask

    initial begin
        rst = 1'b1; evt = 0; en = 0; clr_mask = 0; clr_we = 0;
        pol_hi = 1'b1; dly_en = 0; auto_wake = 0; clk_rdy = 0;
        // R7: reset state for both polarities
        cur_req = "R7";
        idle(2);
        pol_hi = 1'b0;
        idle(1);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // R6: polarity flip while idle moves pin at once, no active pulse
        cur_req = "R6";
        pol_hi = 1'b1;
        idle(1);
        pol_hi = 1'b0;
        idle(1);
        pol_hi = 1'b1;

        // R1 / R5: magic packet (bit 2) with its enable off
        cur_req = "R1";
        step(4'b0100, 1'b0, 4'h0);
        idle(3);
        cur_req = "R5";
        en = 4'b1011;
        idle(3);

        // R4 / R10: enable bit 2 -> pin follows one cycle later
        cur_req = "R4";
        en = 4'b0100;
        idle(1);
        cur_req = "R10";
        idle(2);

        // R2: clear with mask 0 ignored when strobe low, then real clear
        cur_req = "R2";
        step(4'h0, 1'b0, 4'b0100);
        idle(1);
        step(4'h0, 1'b1, 4'b0100);
        idle(3);

        // R3: event and clear on bit 3 at the same edge
        cur_req = "R3";
        en = 4'b1000;
        step(4'b1000, 1'b1, 4'b1000);
        idle(3);

        // R6: active low with a pending event
        cur_req = "R6";
        pol_hi = 1'b0;
        idle(2);

        // R8: hold-off with auto wake-up, release on clock ready
        cur_req = "R8";
        auto_wake = 1'b1; dly_en = 1'b1; clk_rdy = 1'b0;
        idle(4);
        clk_rdy = 1'b1;
        idle(3);

        // R9: without auto wake-up the delay bit does nothing
        cur_req = "R9";
        auto_wake = 1'b0; clk_rdy = 1'b0;
        idle(4);
        step(4'h0, 1'b1, 4'hF);
        step(4'b0010, 1'b0, 4'h0);
        en = 4'b0010;
        idle(3);

        // R1: every source in turn
        cur_req = "R1";
        en = 4'h0;
        step(4'h0, 1'b1, 4'hF);
        for (int b = 0; b < 4; b++) step(4'(1 << b), 1'b0, 4'h0);
        idle(2);

        // R3 / R8: mixed random traffic
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] re;
            re = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            if (($urandom % 16) == 0) en = 4'($urandom);
            if (($urandom % 32) == 0) pol_hi = 1'($urandom);
            if (($urandom % 8) == 0) clk_rdy = 1'($urandom);
            if (($urandom % 64) == 0) auto_wake = 1'($urandom);
            if (($urandom % 64) == 0) dly_en = 1'($urandom);
            step(re, 1'(($urandom % 5) == 0), 4'($urandom));
        end
        idle(2);
        done = 1;
    end

    initial begin
        wait (done || cycles > WATCHDOG_CYCLES);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG_CYCLES);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule